// File: doc/BRIEF.md
# Descriptor Ring Head/Tail Tracker

This block keeps track of one circular descriptor ring of a network adapter, for either the receive or the transmit direction. Software programs the ring base address, the ring size in bytes and the tail index. From these the block works out which descriptors it may pull into a small on-chip cache. It issues fetch requests for them and counts them as unused. When the datapath signals that a cached descriptor has been consumed, that entry becomes used. The block then sends writeback requests that return used entries to memory and move the hardware head index forward.

Descriptors are 16 bytes, so every address is the base plus sixteen times an index. Only the counts and pointers are kept here. The memory transfers are done by a separate engine that answers each request with a one-cycle acknowledge. Writebacks come in two kinds. A stall writeback is rounded so that it ends on a cache-line boundary. A drain writeback has no alignment and flushes everything once the ring has nothing left to fetch. Used entries are only retired when the writeback is acknowledged. That completion can chain a second writeback and can start a new fetch.

Top module: `desc_ring_tracker`

## Requirements
- R1: The ring size in descriptors is the value written with `len_we_i`, shifted right by 4; bits [3:0] of that write are ignored. The head and cache pointers wrap to zero when they reach the ring size.
- R2: A tail write starts a fetch attempt only while `run_i` is high. A tail write made while `run_i` is low has no later effect.
- R3: A fetch request carries a count equal to the smaller of two values: the distance from the cache pointer to the tail, or to the ring end if the tail is behind the cache pointer; and the free cache room (CACHE_DEPTH minus used minus unused). Its address is base + cache pointer × 16. A count of zero issues no request.
- R4: A fetch or writeback request stays high, with a stable address and count, until it is acknowledged. Only one fetch and one writeback are outstanding at a time.
- R5: A `consume_i` pulse moves one entry from unused to used. It is ignored when no unused entry is held.
- R6: A writeback address is base + head × 16. On the acknowledge, `head_o` advances by the count, and `wb_done_o` pulses for exactly one cycle in the following cycle.
- R7: Used entries stay in the cache, and keep occupying cache room, until their writeback is acknowledged.
- R8: When a writeback covered fewer entries than were used at issue (because it was clipped at the ring end or by alignment), a further writeback with the same alignment mode is issued right after the acknowledge.
- R9: After a writeback completes, a fetch attempt is started only if both `run_i` and `idle_i` are high.
- R10: When no unused entry is held, no fetch is pending, the cache pointer equals the tail and used entries exist, a writeback with zero alignment is issued for all used entries, clipped at the ring end.
- R11: A `stall_i` pulse asks for a writeback in line mode. Its end index is rounded down to a multiple of LINE_BYTES/16 descriptors unless it ends exactly at the ring end. If the rounded count is zero, the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Device running (not draining) |
| idle_i | input | 1 | Datapath idle; allows a fetch after a writeback |
| base_we_i | input | 1 | Write strobe for the ring base address |
| len_we_i | input | 1 | Write strobe for the ring size in bytes |
| tail_we_i | input | 1 | Write strobe for the tail index |
| wdata_i | input | ADDR_W | Register write data |
| fetch_req_o | output | 1 | Fetch request |
| fetch_ack_i | input | 1 | Fetch acknowledge |
| fetch_addr_o | output | ADDR_W | Fetch start address |
| fetch_cnt_o | output | CNT_W | Descriptors to fetch |
| consume_i | input | 1 | One cached descriptor consumed |
| stall_i | input | 1 | FIFO stall; request a line-aligned writeback |
| wb_req_o | output | 1 | Writeback request |
| wb_ack_i | input | 1 | Writeback acknowledge |
| wb_addr_o | output | ADDR_W | Writeback start address |
| wb_cnt_o | output | CNT_W | Descriptors to write back |
| head_o | output | IDX_W | Hardware head index |
| wb_done_o | output | 1 | One-cycle writeback-complete event |

## Verification
The bench builds the block with IDX_W=8, CACHE_DEPTH=4 and LINE_BYTES=64. A 128-byte ring therefore holds 8 descriptors, and stall writebacks group entries in fours. With only four cache slots, a single tail write already hits the cache-room limit. A few steps bring both pointers to the ring end, so the wrap, the ring-end clip with its follow-up writeback, and the alignment trim that drops a request can all be reached within a short sequence.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic {
    ALN_ZERO = 1'b0,
    ALN_LINE = 1'b1
  } wb_aln_e;
endpackage

// File: rtl/drt_regs.sv
module drt_regs #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic              len_we_i,
  input  logic              tail_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  len_o,
  output logic [IDX_W-1:0]  tail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      len_o  <= '0;
      tail_o <= '0;
    end else begin
      if (base_we_i) base_o <= wdata_i;
      if (len_we_i)  len_o  <= wdata_i[IDX_W+3:4];  // bytes / 16
      if (tail_we_i) tail_o <= wdata_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/drt_fetch.sv
module drt_fetch #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 16,
  parameter int CNT_W       = 4,
  parameter int CACHE_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic              tail_wr_i,
  input  logic              wb_done_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [CNT_W-1:0]  used_i,
  input  logic [CNT_W-1:0]  unused_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IDX_W-1:0]  cptr_o,
  output logic              active_o
);
  localparam int SUM_W = IDX_W + 1;

  logic              busy_q, pend_q, pend_d, start;
  logic [IDX_W-1:0]  cptr_q, avail;
  logic [CNT_W-1:0]  room, cnt_c, cnt_q;
  logic [SUM_W-1:0]  nxt;
  logic [ADDR_W-1:0] addr_q;

  // entries up to the tail, or up to the ring end when the tail has wrapped
  assign avail = (tail_i >= cptr_q) ? tail_i - cptr_q : len_i - cptr_q;
  assign room  = CNT_W'(CACHE_DEPTH) - used_i - unused_i;
  assign cnt_c = (32'(avail) < 32'(room)) ? CNT_W'(avail) : room;
  assign nxt   = SUM_W'(cptr_q) + SUM_W'(cnt_q);
  assign start = (tail_wr_i && run_i) || (wb_done_i && run_i && idle_i);

  always_comb begin
    pend_d = pend_q || start;
    if (!busy_q && pend_q) pend_d = start;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cptr_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (!busy_q && pend_q) begin
        busy_q <= (cnt_c != '0);
        cnt_q  <= cnt_c;
        addr_q <= base_i + (ADDR_W'(cptr_q) << 4);
      end else if (busy_q && ack_i) begin
        busy_q <= 1'b0;
        cptr_q <= (nxt >= SUM_W'(len_i)) ? IDX_W'(nxt - SUM_W'(len_i)) : IDX_W'(nxt);
      end
    end
  end

  assign req_o    = busy_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign cptr_o   = cptr_q;
  assign active_o = busy_q || pend_q;
endmodule

// File: rtl/drt_wb.sv
module drt_wb
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 16,
  parameter int CNT_W    = 4,
  parameter int ALN_MASK = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [IDX_W-1:0]  cptr_i,
  input  logic              fetch_active_i,
  input  logic [CNT_W-1:0]  used_i,
  input  logic [CNT_W-1:0]  unused_i,
  input  logic              stall_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              done_o
);
  localparam int SUM_W = IDX_W + 1;

  logic              busy_q, cont_q, stall_q, more_q, done_q, drain, go;
  wb_aln_e           aln_q, cont_aln_q, aln_c;
  logic [IDX_W-1:0]  head_q, space;
  logic [CNT_W-1:0]  raw, cnt_c, cnt_q;
  logic [SUM_W-1:0]  end_all, end_trim, nxt;
  logic [ADDR_W-1:0] addr_q;

  assign drain = (used_i != '0) && (unused_i == '0) && !fetch_active_i && (cptr_i == tail_i);
  assign go    = !busy_q && (cont_q || drain || stall_q);
  // priority: continuation, then drain, then stall
  assign aln_c = cont_q ? cont_aln_q : (drain ? ALN_ZERO : ALN_LINE);

  assign space    = len_i - head_q;
  assign raw      = (32'(used_i) < 32'(space)) ? used_i : CNT_W'(space);
  assign end_all  = SUM_W'(head_q) + SUM_W'(raw);
  assign end_trim = end_all & ~SUM_W'(ALN_MASK);
  assign nxt      = SUM_W'(head_q) + SUM_W'(cnt_q);

  always_comb begin
    if (aln_c == ALN_LINE && end_all != SUM_W'(len_i))
      cnt_c = (end_trim > SUM_W'(head_q)) ? CNT_W'(end_trim - SUM_W'(head_q)) : '0;
    else
      cnt_c = raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cont_q     <= 1'b0;
      stall_q    <= 1'b0;
      more_q     <= 1'b0;
      done_q     <= 1'b0;
      aln_q      <= ALN_ZERO;
      cont_aln_q <= ALN_ZERO;
      head_q     <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
    end else begin
      done_q <= busy_q && ack_i;
      if (go) begin
        busy_q  <= (cnt_c != '0);
        cnt_q   <= cnt_c;
        addr_q  <= base_i + (ADDR_W'(head_q) << 4);
        aln_q   <= aln_c;
        more_q  <= (used_i > cnt_c) && (cnt_c != '0);
        cont_q  <= 1'b0;
        stall_q <= stall_i;
      end else begin
        stall_q <= stall_q || stall_i;
        if (busy_q && ack_i) begin
          busy_q     <= 1'b0;
          head_q     <= (nxt >= SUM_W'(len_i)) ? IDX_W'(nxt - SUM_W'(len_i)) : IDX_W'(nxt);
          cont_q     <= more_q;
          cont_aln_q <= aln_q;
        end
      end
    end
  end

  assign req_o  = busy_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign head_o = head_q;
  assign done_o = done_q;
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 16,
  parameter int CACHE_DEPTH = 8,
  parameter int LINE_BYTES  = 64,
  localparam int CNT_W      = $clog2(CACHE_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic              base_we_i,
  input  logic              len_we_i,
  input  logic              tail_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              fetch_req_o,
  input  logic              fetch_ack_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [CNT_W-1:0]  fetch_cnt_o,
  input  logic              consume_i,
  input  logic              stall_i,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [CNT_W-1:0]  wb_cnt_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              wb_done_o
);
  localparam int ALN_MASK = (LINE_BYTES - 1) >> 4;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  len_q, tail_q, cptr;
  logic [CNT_W-1:0]  used_q, unused_q;
  logic              fetch_active, cons_ok, fetch_fin, wb_fin;

  drt_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .base_we_i, .len_we_i, .tail_we_i, .wdata_i,
    .base_o(base_q), .len_o(len_q), .tail_o(tail_q)
  );

  drt_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .CACHE_DEPTH(CACHE_DEPTH)) u_fetch (
    .clk_i, .rst_ni, .run_i, .idle_i,
    .tail_wr_i(tail_we_i), .wb_done_i(wb_done_o),
    .base_i(base_q), .len_i(len_q), .tail_i(tail_q),
    .used_i(used_q), .unused_i(unused_q), .ack_i(fetch_ack_i),
    .req_o(fetch_req_o), .addr_o(fetch_addr_o), .cnt_o(fetch_cnt_o),
    .cptr_o(cptr), .active_o(fetch_active)
  );

  drt_wb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .ALN_MASK(ALN_MASK)) u_wb (
    .clk_i, .rst_ni,
    .base_i(base_q), .len_i(len_q), .tail_i(tail_q), .cptr_i(cptr),
    .fetch_active_i(fetch_active), .used_i(used_q), .unused_i(unused_q),
    .stall_i, .ack_i(wb_ack_i),
    .req_o(wb_req_o), .addr_o(wb_addr_o), .cnt_o(wb_cnt_o),
    .head_o, .done_o(wb_done_o)
  );

  assign cons_ok   = consume_i && (unused_q != '0);
  assign fetch_fin = fetch_req_o && fetch_ack_i;
  assign wb_fin    = wb_req_o && wb_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q   <= '0;
      unused_q <= '0;
    end else begin
      unused_q <= unused_q + (fetch_fin ? fetch_cnt_o : '0) - CNT_W'(cons_ok);
      used_q   <= used_q + CNT_W'(cons_ok) - (wb_fin ? wb_cnt_o : '0);
    end
  end
endmodule

// File: rtl/desc_ring_tracker_chk.sv
module desc_ring_tracker_chk #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 16,
  parameter int CNT_W       = 4,
  parameter int CACHE_DEPTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_o,
  input logic              fetch_ack_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [CNT_W-1:0]  fetch_cnt_o,
  input logic              wb_req_o,
  input logic              wb_ack_i,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic [CNT_W-1:0]  wb_cnt_o,
  input logic [IDX_W-1:0]  head_o,
  input logic              wb_done_o,
  input logic [CNT_W-1:0]  used_q,
  input logic [CNT_W-1:0]  unused_q,
  input logic [IDX_W-1:0]  len_q,
  input logic [IDX_W-1:0]  tail_q,
  input logic [IDX_W-1:0]  cptr
);
  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o) && $stable(fetch_cnt_o)); // R4
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o) && $stable(wb_cnt_o)); // R4
  AST_FETCH_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (fetch_cnt_o != '0) && (32'(fetch_cnt_o) <= CACHE_DEPTH)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(used_q) + 32'(unused_q) <= CACHE_DEPTH); // R3
  AST_FETCH_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req_o) && ($past(tail_q) >= cptr) |->
      32'(cptr) + 32'(fetch_cnt_o) <= 32'($past(tail_q))); // R3
  AST_FETCH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req_o) |-> 32'(cptr) + 32'(fetch_cnt_o) <= 32'(len_q)); // R1
  AST_HEAD_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o != $past(head_o)) |-> $past(wb_req_o && wb_ack_i)); // R6
  AST_HEAD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) |-> (head_o < len_q)); // R1
  AST_RETIRE_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q < $past(used_q)) |-> $past(wb_req_o && wb_ack_i)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_done_o |=> !wb_done_o); // R6
  AST_WB_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> (wb_cnt_o != '0) && (wb_cnt_o <= used_q)); // R11
endmodule

bind desc_ring_tracker desc_ring_tracker_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .CACHE_DEPTH(CACHE_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fetch_req_o(fetch_req_o), .fetch_ack_i(fetch_ack_i),
  .fetch_addr_o(fetch_addr_o), .fetch_cnt_o(fetch_cnt_o),
  .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i),
  .wb_addr_o(wb_addr_o), .wb_cnt_o(wb_cnt_o),
  .head_o(head_o), .wb_done_o(wb_done_o),
  .used_q(used_q), .unused_q(unused_q),
  .len_q(len_q), .tail_q(tail_q), .cptr(cptr)
);

// File: tb/desc_ring_tracker_test.sv
module desc_ring_tracker_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;
  localparam int DEPTH  = 4;
  localparam int LINE   = 64;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [31:0] BASE = 32'h1000;
  localparam int RING = 8;

  localparam logic [1:0] OP_NOP = 2'd0, OP_TAIL = 2'd1, OP_CONS = 2'd2, OP_STALL = 2'd3;
  localparam logic [1:0] EX_NONE = 2'd0, EX_FETCH = 2'd1, EX_WB = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  arg;
    logic [1:0]  kind;
    logic [3:0]  cnt;
    logic [31:0] addr;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t STEPS [NSTEP] = '{
    '{OP_TAIL,  8'd6, EX_FETCH, 4'd4, 32'h1000}, // R3 room-limited
    '{OP_CONS,  8'd4, EX_NONE,  4'd0, 32'h0},    // R10 cptr != tail
    '{OP_TAIL,  8'd6, EX_NONE,  4'd0, 32'h0},    // R7 used still hold room
    '{OP_STALL, 8'd0, EX_WB,    4'd4, 32'h1000}, // R11 aligned end at 4
    '{OP_NOP,   8'd0, EX_FETCH, 4'd2, 32'h1040}, // R9 R7 fetch after retire
    '{OP_CONS,  8'd1, EX_NONE,  4'd0, 32'h0},    // R10 unused left
    '{OP_CONS,  8'd1, EX_WB,    4'd2, 32'h1040}, // R10 drain
    '{OP_TAIL,  8'd2, EX_FETCH, 4'd2, 32'h1060}, // R3 R1 clipped at ring end
    '{OP_CONS,  8'd2, EX_NONE,  4'd0, 32'h0},
    '{OP_STALL, 8'd0, EX_WB,    4'd2, 32'h1060}, // R11 R1 ring end, head wraps
    '{OP_NOP,   8'd0, EX_FETCH, 4'd2, 32'h1000}, // R9 R1 wrapped cache ptr
    '{OP_CONS,  8'd1, EX_NONE,  4'd0, 32'h0},
    '{OP_STALL, 8'd0, EX_NONE,  4'd0, 32'h0},    // R11 trimmed to zero
    '{OP_CONS,  8'd1, EX_WB,    4'd2, 32'h1000}, // R10
    '{OP_TAIL,  8'd6, EX_FETCH, 4'd4, 32'h1020}, // R3
    '{OP_CONS,  8'd4, EX_WB,    4'd4, 32'h1020}, // R10
    '{OP_TAIL,  8'd2, EX_FETCH, 4'd2, 32'h1060}, // R3 ring end
    '{OP_TAIL,  8'd2, EX_FETCH, 4'd2, 32'h1000}, // R3 after wrap
    '{OP_CONS,  8'd4, EX_WB,    4'd2, 32'h1060}, // R10 clipped
    '{OP_NOP,   8'd0, EX_WB,    4'd2, 32'h1000}  // R8 follow-up writeback
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 1'b1, idle_i = 1'b1;
  logic base_we_i = 1'b0, len_we_i = 1'b0, tail_we_i = 1'b0;
  logic [ADDR_W-1:0] wdata_i = '0;
  logic fetch_ack_i = 1'b0, wb_ack_i = 1'b0, consume_i = 1'b0, stall_i = 1'b0;
  logic fetch_req_o, wb_req_o, wb_done_o;
  logic [ADDR_W-1:0] fetch_addr_o, wb_addr_o;
  logic [CNT_W-1:0] fetch_cnt_o, wb_cnt_o;
  logic [IDX_W-1:0] head_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  desc_ring_tracker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CACHE_DEPTH(DEPTH), .LINE_BYTES(LINE)) uut (
    .clk_i(clk), .rst_ni, .run_i, .idle_i, .base_we_i, .len_we_i, .tail_we_i, .wdata_i,
    .fetch_req_o, .fetch_ack_i, .fetch_addr_o, .fetch_cnt_o,
    .consume_i, .stall_i, .wb_req_o, .wb_ack_i, .wb_addr_o, .wb_cnt_o,
    .head_o, .wb_done_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int which, input logic [31:0] v);
    wdata_i = v;
    base_we_i = (which == 0);
    len_we_i  = (which == 1);
    tail_we_i = (which == 2);
    @(negedge clk);
    base_we_i = 1'b0; len_we_i = 1'b0; tail_we_i = 1'b0;
  endtask

  task automatic consume(input int n);
    for (int k = 0; k < n; k++) begin
      consume_i = 1'b1;
      @(negedge clk);
      consume_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic stall();
    stall_i = 1'b1;
    @(negedge clk);
    stall_i = 1'b0;
  endtask

  task automatic expect_fetch(input int c, input logic [31:0] a, input string tag);
    int w = 0;
    while (!fetch_req_o && w < 40) begin @(negedge clk); w++; end
    chk({tag, " R3 fetch issued"}, 32'(fetch_req_o), 32'd1);
    if (fetch_req_o) begin
      chk({tag, " R3 fetch count"}, 32'(fetch_cnt_o), 32'(c));
      chk({tag, " R3 fetch address"}, fetch_addr_o, a);
      @(negedge clk);
      chk({tag, " R4 fetch held"}, 32'(fetch_req_o && fetch_cnt_o == CNT_W'(c) && fetch_addr_o == a), 32'd1);
      fetch_ack_i = 1'b1;
      @(negedge clk);
      fetch_ack_i = 1'b0;
    end
  endtask

  task automatic expect_wb(input int c, input logic [31:0] a, input string tag);
    int w = 0;
    int hexp;
    while (!wb_req_o && w < 40) begin @(negedge clk); w++; end
    chk({tag, " R6 writeback issued"}, 32'(wb_req_o), 32'd1);
    if (wb_req_o) begin
      chk({tag, " R6 writeback count"}, 32'(wb_cnt_o), 32'(c));
      chk({tag, " R6 writeback address"}, wb_addr_o, a);
      @(negedge clk);
      chk({tag, " R4 writeback held"}, 32'(wb_req_o && wb_cnt_o == CNT_W'(c) && wb_addr_o == a), 32'd1);
      hexp = (int'((a - BASE) >> 4) + c) % RING;
      wb_ack_i = 1'b1;
      @(negedge clk);
      wb_ack_i = 1'b0;
      chk({tag, " R6 R1 head after ack"}, 32'(head_o), 32'(hexp));
      chk({tag, " R6 done pulse"}, 32'(wb_done_o), 32'd1);
      @(negedge clk);
      chk({tag, " R6 done single cycle"}, 32'(wb_done_o), 32'd0);
    end
  endtask

  task automatic expect_quiet(input string tag);
    logic seen = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (fetch_req_o || wb_req_o) seen = 1'b1;
    end
    chk({tag, " no request"}, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R4 act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 reset head", 32'(head_o), 32'd0);
    chk("R4 reset fetch_req", 32'(fetch_req_o), 32'd0);
    chk("R4 reset wb_req", 32'(wb_req_o), 32'd0);
    chk("R6 reset done", 32'(wb_done_o), 32'd0);

    reg_wr(0, BASE);
    reg_wr(1, 32'h8F);  // R1 low nibble ignored: ring of 8

    for (int i = 0; i < NSTEP; i++) begin
      string tag;
      tag = $sformatf("step %0d", i);
      case (STEPS[i].op)
        OP_TAIL:  reg_wr(2, 32'(STEPS[i].arg));
        OP_CONS:  consume(int'(STEPS[i].arg));
        OP_STALL: stall();
        default:  ;
      endcase
      case (STEPS[i].kind)
        EX_FETCH: expect_fetch(int'(STEPS[i].cnt), STEPS[i].addr, tag);
        EX_WB:    expect_wb(int'(STEPS[i].cnt), STEPS[i].addr, tag);
        default:  expect_quiet({tag, " R7 R10 R11"});
      endcase
    end

    // R2: tail write ignored while not running
    run_i = 1'b0;
    reg_wr(2, 32'd5);
    expect_quiet("R2 not running");
    run_i = 1'b1;
    expect_quiet("R2 no late fetch");
    reg_wr(2, 32'd5);
    expect_fetch(3, 32'h1020, "R2 running");

    // R9: no fetch after writeback while datapath busy
    consume(3);
    begin
      int w = 0;
      while (!wb_req_o && w < 40) begin @(negedge clk); w++; end
    end
    run_i = 1'b0;
    reg_wr(2, 32'd7);
    run_i = 1'b1;
    idle_i = 1'b0;
    expect_wb(3, 32'h1020, "R10 drain before idle test");
    expect_quiet("R9 datapath busy");
    idle_i = 1'b1;
    reg_wr(2, 32'd7);
    expect_fetch(2, 32'h1050, "R9 fetch on tail write");

    // R5: consumes beyond the unused count leave used unchanged
    consume(2);
    expect_wb(2, 32'h1050, "R10 drain");
    consume(2);
    stall();
    expect_quiet("R5 consume with empty cache");
    chk("R5 head unchanged", 32'(head_o), 32'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule